// File: doc/BRIEF.md
# Bus Cycle Termination Sequencer

This block runs one processor bus access from start to end. The access is either a single transfer or a four-beat line transfer. On every rising clock edge it samples two active-low termination inputs together: transfer acknowledge (`taN`) and transfer error (`teaN`). From that pair it decides to hold the current beat, complete the beat, restart the access, or abort it.

For line reads the requester supplies a mask of the beats that carry the long word (or, for a misaligned operand, both long words) that the execution unit actually asked for. When a line read is aborted by an error, the block uses this mask to decide the outcome:

- It raises an exception strobe at once, or
- It quietly drops the line, so that the cache does not take it and the line is fetched again on a later reference.

Writes and single transfers always raise the exception when they end in error.

All result indications are registered one-cycle pulses. They appear in the cycle after the clock edge that sampled the termination pair.

Top module: `busTermSeq`

## Requirements
- R1: While `rstN` is low, and in the first cycle after reset, `busy` and every pulse output are 0, and `beatIdx` and `excBeat` are 0.
- R2: `startReq` sampled while idle loads `lineAccess`, `writeAccess` and `wantMask`, sets `beatIdx` to 0 and raises `busy` after that edge. `startReq` sampled while busy has no effect on `beatIdx`, `busy` or any pulse.
- R3: While busy, a sample with `taN`=1 and `teaN`=1 is a wait state. `beatIdx` and `busy` do not change and no pulse is issued, for any number of consecutive waits.
- R4: While busy, a sample with `taN`=0 and `teaN`=1 pulses `beatAck` for one cycle. On a line access with `beatIdx` below 3 it increments `beatIdx`. On the last beat (beat 3 of a line, or the only beat of a single transfer) it also pulses `accessDone` and clears `busy`.
- R5: `fillValid` pulses, together with `accessDone`, only when a line read completes all four beats. It never pulses for a write, for a single transfer, or for an aborted line.
- R6: While busy, a sample with `taN`=0 and `teaN`=0 pulses `retryReq` for one cycle, returns `beatIdx` to 0 and keeps `busy` high.
- R7: While busy, a sample with `taN`=1 and `teaN`=0 is a bus error. It clears `busy` on that edge, and no further beat is acknowledged.
- R8: A bus error on a write access (line or single), or on a single read, pulses `excStrobe`.
- R9: A bus error on a line read pulses `excStrobe` if the failing beat is beat 0 or bit `wantMask[beatIdx]` is set. Otherwise it pulses `lineDropped` instead, and `fillValid` stays 0.
- R10: With `excStrobe`, `excBeat` gives the beat index at which the error was sampled and `excWrite` gives the access direction (1 = write). Both hold their values until the next exception.
- R11: A misaligned operand is marked by two set bits in `wantMask`. A bus error on either of those beats pulses `excStrobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin an access (taken only when idle) |
| lineAccess | input | 1 | 1 = four-beat line, 0 = single transfer |
| writeAccess | input | 1 | 1 = write, 0 = read |
| wantMask | input | BEATS (4) | Beats carrying requested data; bit n = beat n |
| taN | input | 1 | Transfer acknowledge, active low |
| teaN | input | 1 | Transfer error, active low |
| busy | output | 1 | Access in progress |
| beatIdx | output | BW (2) | Current beat of the access |
| beatAck | output | 1 | Pulse: a beat completed normally |
| accessDone | output | 1 | Pulse: access completed normally |
| retryReq | output | 1 | Pulse: access restarts from beat 0 |
| fillValid | output | 1 | Pulse: full line read may enter the cache |
| lineDropped | output | 1 | Pulse: line read aborted without exception |
| excStrobe | output | 1 | Pulse: take the access-error exception |
| excBeat | output | BW (2) | Beat index of the last exception |
| excWrite | output | 1 | Direction of the last exception access |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- **Error on an unrequested later beat of a line read.** A design that ignores the mask would raise a spurious exception, or would still report the line as fillable.
- **Misaligned masks with two set bits.** A design that honours only one requested beat would miss the exception on the other.
- **Retry in mid-line.** A wrong design would resume from the current beat rather than from beat 0.
- **Long runs of wait states.** A wrong design would advance or time out the beat counter.
- **Start requests arriving while busy.** A wrong design would reload the attributes or reset the beat.
- **Errors on beat 0 and on writes.** A wrong design would consult the mask where the exception is unconditional.

// File: rtl/busTermPkg.sv
package busTermPkg;

  typedef enum logic [1:0] {
    TERM_WAIT,
    TERM_ACK,
    TERM_RETRY,
    TERM_ERR
  } termKind_e;

  typedef struct packed {
    logic load;
    logic ack;
    logic last;
    logic retry;
    logic abortExc;
    logic abortQuiet;
    logic fill;
  } ctrlStrobe_t;

  // Both active-low inputs are judged from one and the same edge sample.
  function automatic termKind_e decodeTerm(input logic taN, input logic teaN);
    case ({taN, teaN})
      2'b01:   return TERM_ACK;
      2'b00:   return TERM_RETRY;
      2'b10:   return TERM_ERR;
      default: return TERM_WAIT;
    endcase
  endfunction

endpackage

// File: rtl/busTermCtrl.sv
module busTermCtrl
  import busTermPkg::*;
#(
  parameter int BEATS = 4,
  localparam int BW = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              taN,
  input  logic              teaN,
  input  logic [BW-1:0]     beatIn,
  input  logic              lineQ,
  input  logic              writeQ,
  input  logic [BEATS-1:0]  maskQ,
  output ctrlStrobe_t       strobe,
  output logic              active
);

  typedef enum logic {ST_IDLE, ST_ACTIVE} ctrlState_e;
  ctrlState_e stateQ, stateD;
  termKind_e  kind;
  logic       lastBeat;
  logic       wanted;

  assign kind     = decodeTerm(taN, teaN);
  assign lastBeat = !lineQ || (beatIn == BW'(BEATS - 1));
  // Beat 0 always carries the requested word; later beats only if masked.
  assign wanted   = writeQ || !lineQ || (beatIn == '0) || maskQ[beatIn];
  assign active   = (stateQ == ST_ACTIVE);

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    if (stateQ == ST_IDLE) begin
      strobe.load = startReq;
      if (startReq) stateD = ST_ACTIVE;
    end else begin
      case (kind)
        TERM_ACK: begin
          strobe.ack  = 1'b1;
          strobe.last = lastBeat;
          strobe.fill = lastBeat && lineQ && !writeQ;
          if (lastBeat) stateD = ST_IDLE;
        end
        TERM_RETRY: strobe.retry = 1'b1;
        TERM_ERR: begin
          strobe.abortExc   = wanted;
          strobe.abortQuiet = !wanted;
          stateD            = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  a_r3_wait_holds_beat: assert property (@(posedge clk) disable iff (!rstN)
    (active && taN && teaN) |=> (active && $stable(beatIn)));

  a_r6_retry_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (active && !taN && !teaN) |=> (active && beatIn == '0));

  a_r7_error_ends_access: assert property (@(posedge clk) disable iff (!rstN)
    (active && taN && !teaN) |=> !active);

endmodule

// File: rtl/busTermPath.sv
module busTermPath
  import busTermPkg::*;
#(
  parameter int BEATS = 4,
  localparam int BW = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              lineIn,
  input  logic              writeIn,
  input  logic [BEATS-1:0]  maskIn,
  output logic [BW-1:0]     beatQ,
  output logic              lineQ,
  output logic              writeQ,
  output logic [BEATS-1:0]  maskQ,
  output logic              beatAckQ,
  output logic              doneQ,
  output logic              fillQ,
  output logic              retryQ,
  output logic              quietQ,
  output logic              excQ,
  output logic [BW-1:0]     excBeatQ,
  output logic              excWriteQ
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatQ  <= '0;
      lineQ  <= 1'b0;
      writeQ <= 1'b0;
      maskQ  <= '0;
    end else if (strobe.load) begin
      beatQ  <= '0;
      lineQ  <= lineIn;
      writeQ <= writeIn;
      maskQ  <= maskIn;
    end else if (strobe.retry) begin
      beatQ <= '0;
    end else if (strobe.ack && !strobe.last) begin
      beatQ <= beatQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatAckQ  <= 1'b0;
      doneQ     <= 1'b0;
      fillQ     <= 1'b0;
      retryQ    <= 1'b0;
      quietQ    <= 1'b0;
      excQ      <= 1'b0;
      excBeatQ  <= '0;
      excWriteQ <= 1'b0;
    end else begin
      beatAckQ <= strobe.ack;
      doneQ    <= strobe.ack && strobe.last;
      fillQ    <= strobe.fill;
      retryQ   <= strobe.retry;
      quietQ   <= strobe.abortQuiet;
      excQ     <= strobe.abortExc;
      if (strobe.abortExc) begin
        excBeatQ  <= beatQ;
        excWriteQ <= writeQ;
      end
    end
  end

  a_r8_outcomes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({excQ, retryQ, fillQ, quietQ}));

  a_r5_fill_only_full_read: assert property (@(posedge clk) disable iff (!rstN)
    fillQ |-> (doneQ && lineQ && !writeQ && beatQ == BW'(BEATS - 1)));

  a_r4_single_stays_beat0: assert property (@(posedge clk) disable iff (!rstN)
    (!lineQ) |-> (beatQ == '0));

endmodule

// File: rtl/busTermSeq.sv
module busTermSeq
  import busTermPkg::*;
#(
  parameter int BEATS = 4,
  localparam int BW = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              lineAccess,
  input  logic              writeAccess,
  input  logic [BEATS-1:0]  wantMask,
  input  logic              taN,
  input  logic              teaN,
  output logic              busy,
  output logic [BW-1:0]     beatIdx,
  output logic              beatAck,
  output logic              accessDone,
  output logic              retryReq,
  output logic              fillValid,
  output logic              lineDropped,
  output logic              excStrobe,
  output logic [BW-1:0]     excBeat,
  output logic              excWrite
);

  ctrlStrobe_t       strobe;
  logic              lineQ;
  logic              writeQ;
  logic [BEATS-1:0]  maskQ;

  busTermCtrl #(.BEATS(BEATS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .taN(taN), .teaN(teaN),
    .beatIn(beatIdx), .lineQ(lineQ), .writeQ(writeQ), .maskQ(maskQ),
    .strobe(strobe), .active(busy)
  );

  busTermPath #(.BEATS(BEATS)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lineIn(lineAccess), .writeIn(writeAccess), .maskIn(wantMask),
    .beatQ(beatIdx), .lineQ(lineQ), .writeQ(writeQ), .maskQ(maskQ),
    .beatAckQ(beatAck), .doneQ(accessDone), .fillQ(fillValid),
    .retryQ(retryReq), .quietQ(lineDropped), .excQ(excStrobe),
    .excBeatQ(excBeat), .excWriteQ(excWrite)
  );

endmodule

// File: tb/busTermSeq_bench.sv
module busTermSeq_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0, lineAccess = 1'b0, writeAccess = 1'b0;
  logic [3:0] wantMask = '0;
  logic       taN = 1'b1, teaN = 1'b1;
  logic       busy, beatAck, accessDone, retryReq, fillValid, lineDropped;
  logic       excStrobe, excWrite;
  logic [1:0] beatIdx, excBeat;

  int checks = 0;
  int fails = 0;

  // Reference model state
  logic       mBusy = 0, mLine = 0, mWr = 0;
  logic [3:0] mMask = 0;
  int         mBeat = 0;

  always #5 clk = ~clk;

  busTermSeq u_busTermSeq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lineAccess(lineAccess),
    .writeAccess(writeAccess), .wantMask(wantMask), .taN(taN), .teaN(teaN),
    .busy(busy), .beatIdx(beatIdx), .beatAck(beatAck), .accessDone(accessDone),
    .retryReq(retryReq), .fillValid(fillValid), .lineDropped(lineDropped),
    .excStrobe(excStrobe), .excBeat(excBeat), .excWrite(excWrite)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit excWanted(input logic wr, input logic ln, input int beat,
                                   input logic [3:0] mask);
    return wr || !ln || beat == 0 || mask[beat];
  endfunction

  task automatic cycle(input logic st, input logic ln, input logic wr,
                       input logic [3:0] mask, input logic ta, input logic tea);
    bit eAck = 0, eDone = 0, eFill = 0, eRetry = 0, eExc = 0, eQuiet = 0;
    int eExcBeat = 0;
    bit eExcWr = 0;
    string ctx = "R4";
    string excTag = "R8";
    @(negedge clk);
    startReq = st; lineAccess = ln; writeAccess = wr; wantMask = mask;
    taN = ta; teaN = tea;
    @(posedge clk);
    #1;
    if (!mBusy) begin
      if (st) begin
        mBusy = 1; mLine = ln; mWr = wr; mMask = mask; mBeat = 0; ctx = "R2";
      end
    end else begin
      if (st) ctx = "R2";
      if (!ta && tea) begin
        eAck = 1;
        if (!mLine || mBeat == 3) begin
          eDone = 1; eFill = mLine && !mWr; mBusy = 0;
        end else mBeat++;
      end else if (!ta && !tea) begin
        eRetry = 1; mBeat = 0; ctx = "R6";
      end else if (ta && !tea) begin
        mBusy = 0; ctx = "R7";
        if (excWanted(mWr, mLine, mBeat, mMask)) begin
          eExc = 1; eExcBeat = mBeat; eExcWr = mWr;
          if (mWr || !mLine) excTag = "R8";
          else if ($countones(mMask) == 2 && mMask[mBeat]) excTag = "R11";
          else excTag = "R9";
        end else begin
          eQuiet = 1; excTag = "R9";
        end
      end else if (!st) ctx = "R3";
    end
    chk(ctx, "busy", busy, mBusy);
    chk(ctx, "beatIdx", beatIdx, mBeat);
    chk("R4", "beatAck", beatAck, eAck);
    chk("R4", "accessDone", accessDone, eDone);
    chk("R5", "fillValid", fillValid, eFill);
    chk("R6", "retryReq", retryReq, eRetry);
    chk("R9", "lineDropped", lineDropped, eQuiet);
    chk(excTag, "excStrobe", excStrobe, eExc);
    if (eExc) begin
      chk("R10", "excBeat", excBeat, eExcBeat);
      chk("R10", "excWrite", excWrite, eExcWr);
    end
  endtask

  // ta/tea pairs: ack=01, wait=11, retry=00, error=10
  task automatic idleStart(input logic ln, input logic wr, input logic [3:0] mask);
    cycle(1, ln, wr, mask, 1, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "beatIdx", beatIdx, 0);
    chk("R1", "pulses", {beatAck, accessDone, retryReq, fillValid, lineDropped, excStrobe}, 0);
    chk("R1", "excBeat", excBeat, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1", "busy after reset", busy, 0);

    // Directed: full line read with long waits, start ignored while busy (R2, R3, R5)
    idleStart(1, 0, 4'b0001);
    repeat (20) cycle(0, 0, 0, 4'b0000, 1, 1);
    cycle(0, 0, 0, 0, 0, 1);
    cycle(1, 0, 1, 4'b1111, 1, 1);
    cycle(0, 0, 0, 0, 0, 1);
    cycle(1, 0, 1, 4'b1000, 0, 1);
    cycle(0, 0, 0, 0, 0, 1);
    // Directed: retry mid-line then complete (R6)
    idleStart(1, 0, 4'b0001);
    cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 0, 0);
    repeat (4) cycle(0, 0, 0, 0, 0, 1);
    // Directed: error on unrequested beat 2 -> dropped (R9)
    idleStart(1, 0, 4'b0001);
    repeat (2) cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 1, 0);
    cycle(0, 0, 0, 0, 0, 1);   // ack after abort must do nothing (R7)
    // Directed: misaligned pair beats 1/2, error on beat 2 (R11)
    idleStart(1, 0, 4'b0110);
    repeat (2) cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 1, 0);
    // Directed: misaligned pair, error on beat 1 (R11)
    idleStart(1, 0, 4'b0110);
    cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 1, 0);
    // Directed: line write error on beat 3 (R8, R10)
    idleStart(1, 1, 4'b0001);
    repeat (3) cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 1, 0);
    // Directed: single read error (R8), single write ok
    idleStart(0, 0, 4'b0001);
    cycle(0, 0, 0, 0, 1, 0);
    idleStart(0, 1, 4'b0001);
    cycle(0, 0, 0, 0, 0, 1);

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      int  pick = $urandom_range(0, 99);
      logic ta, tea;
      logic [3:0] m;
      if (pick < 50)      begin ta = 0; tea = 1; end
      else if (pick < 75) begin ta = 1; tea = 1; end
      else if (pick < 83) begin ta = 0; tea = 0; end
      else                begin ta = 1; tea = 0; end
      if ($urandom_range(0, 1) == 1) begin
        int a = $urandom_range(0, 3);
        m = 4'b0001 << a;
      end else begin
        int a = $urandom_range(0, 2);
        m = 4'b0011 << a;
      end
      cycle(($urandom_range(0, 3) == 0) ? 1'b1 : 1'b0, 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), m, ta, tea);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule